// File: doc/BRIEF.md
# Address-Masked GPIO Register Bank

This block is an eight-pin general-purpose I/O peripheral that sits on a simple APB-style register bus. It holds one direction bit and one output-data bit per pin, and it passes every pad input through a two-flop synchronizer. The synchronized inputs go to the data read path, and they are also brought out on a port for other logic, such as a separate interrupt detector.

Data accesses use the address as a per-access bit mask. Byte address bits [9:2] select the pins that an access touches. A write changes only the selected pins, so software can set or clear one pin without a read-modify-write. A read returns zero for every pin outside the mask. A data write changes only pins that are currently outputs. For that reason, software must set the direction first and then write the output value.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset, `pin_oe` and `pin_out` are all zero, the direction register reads 0x00, and every pin is an input.
- R2: The direction register is read/write at byte offset 0x400. Bit n = 1 makes pin n an output, and `pin_oe[n]` follows bit n.
- R3: A write anywhere in the data window (offsets 0x000 to 0x3FC) updates only the output bits selected by address bits [9:2]. Address bit n+2 selects pin n. Every other output bit keeps its value.
- R4: A data write does not change the output bit of a pin that is an input at the time of the write. The same write takes effect once the pin has been made an output.
- R5: On a data read, every bit outside the address mask reads as 0.
- R6: On a data read, a masked bit returns the driven output value for an output pin and the synchronized pad value for an input pin.
- R7: `pin_sync` equals `pin_in` as it was two clock edges earlier.
- R8: Offsets above 0x400 read as zero, and writes to them change neither the direction nor the data.
- R9: A transfer writes only in its access phase (`psel`, `penable` and `pwrite` all high). A setup phase alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid while `psel` is high |
| pin_in | input | 8 | Raw pad input values |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_sync | output | 8 | Synchronized pad inputs |

## Verification
Two functions meet in every data write: the address mask and the direction gating. Together they decide which output bits may change. The bench provokes this with writes whose mask covers a mix of input and output pins. It then judges each output bit separately against a model that requires both the mask bit and the direction bit.

Two functions also meet on a read: the output path and the synchronized input path are merged into one masked word. A read whose mask spans both output and input pins checks that each half comes from its own source. The pad value used for the expected result has been held steady longer than the synchronizer latency.

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank #(
  parameter int NPINS = 8,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [NPINS-1:0] pwdata,
  output logic [NPINS-1:0] prdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_sync
);
  localparam int          MLO     = 2;
  localparam int          MHI     = NPINS + MLO - 1;
  localparam logic [AW:0] DIR_OFS = (AW+1)'(1) << (NPINS + MLO);

  logic [NPINS-1:0] dir_q, out_q, s1_q, s2_q;
  logic [NPINS-1:0] amask, wmask, merged;
  logic             data_sel, dir_sel, wr_en;

  assign amask    = paddr[MHI:MLO];
  assign data_sel = {1'b0, paddr} < DIR_OFS;
  assign dir_sel  = {1'b0, paddr} == DIR_OFS;
  assign wr_en    = psel && penable && pwrite;
  assign wmask    = amask & dir_q;
  assign merged   = (dir_q & out_q) | (~dir_q & s2_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dir_q <= '0;
    else if (wr_en && dir_sel)
      dir_q <= pwdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_q <= '0;
    else if (wr_en && data_sel)
      out_q <= (out_q & ~wmask) | (pwdata & wmask);
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      if (data_sel)     prdata = merged & amask;
      else if (dir_sel) prdata = dir_q;
    end
  end

  assign pin_oe   = dir_q;
  assign pin_out  = out_q;
  assign pin_sync = s2_q;

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R3
  masked_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite) |=>
      ((pin_out ^ $past(pin_out)) & ~$past(paddr[MHI:MLO])) == '0);

  // R4
  input_pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite) |=>
      ((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0);

  // R5
  read_mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && paddr < AW'(DIR_OFS)) |-> (prdata & ~paddr[MHI:MLO]) == '0);

  // R7
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> pin_sync == $past(pin_in, 2));

  // R9
  no_access_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable && pwrite) |=> ($stable(pin_oe) && $stable(pin_out)));

  // R8
  dir_only_at_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && paddr > AW'(DIR_OFS)) |=> $stable(pin_oe));
endmodule

// File: tb/gpio_mask_bank_tb.sv
module gpio_mask_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [7:0] pwdata = '0, pin_in = '0;
  logic [7:0] prdata, pin_oe, pin_out, pin_sync;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  gpio_mask_bank dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pin_sync(pin_sync)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pins_now(string tag, logic [7:0] oe, logic [7:0] o);
    @(negedge clk); #1;
    check({tag, " pin_oe"}, pin_oe, oe);
    check({tag, " pin_out"}, pin_out, o);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk); #1;
      if (psel && penable && !pwrite) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL scoreboard underflow actual=%02h expected=none", prdata);
        end else begin
          check(tag_q.pop_front(), prdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pins_now("R1 reset", 8'h00, 8'h00);
    bus_read(12'h400, 8'h00, "R1 direction after reset");
    bus_read(12'h3FC, 8'h00, "R1 data after reset");

    bus_write(12'h3FC, 8'hFF);
    pins_now("R4 write to inputs", 8'h00, 8'h00);

    bus_write(12'h400, 8'h0F);
    bus_read(12'h400, 8'h0F, "R2 direction readback");
    pins_now("R2 oe", 8'h0F, 8'h00);

    bus_write(12'h3FC, 8'hA5);
    pins_now("R4 partial outputs", 8'h0F, 8'h05);

    bus_write(12'h004, 8'h00);
    pins_now("R3 single pin clear", 8'h0F, 8'h04);
    bus_write(12'h018, 8'hFF);
    pins_now("R3 two pin set", 8'h0F, 8'h06);
    bus_write(12'h000, 8'hFF);
    pins_now("R3 empty mask", 8'h0F, 8'h06);

    // R9: setup phase only
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h3FC; pwdata = 8'h09;
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    pins_now("R9 setup only", 8'h0F, 8'h06);

    pin_in = 8'h3C;
    repeat (4) @(negedge clk);
    bus_read(12'h3FC, 8'h36, "R6 merged read");
    bus_read(12'h3C0, 8'h30, "R5 upper mask read");
    bus_read(12'h004, 8'h00, "R5 pin0 read");
    bus_read(12'h008, 8'h02, "R6 pin1 output read");

    @(negedge clk);
    pin_in = 8'hC3;
    @(negedge clk); #1;
    check("R7 one edge", pin_sync, 8'h3C);
    @(negedge clk); #1;
    check("R7 two edges", pin_sync, 8'hC3);

    bus_write(12'h404, 8'hFF);
    bus_write(12'h800, 8'hFF);
    pins_now("R8 unused writes", 8'h0F, 8'h06);
    bus_read(12'h404, 8'h00, "R8 unused read");
    bus_read(12'hFFC, 8'h00, "R8 top read");
    bus_read(12'h400, 8'h0F, "R8 direction kept");

    bus_write(12'h400, 8'hFF);
    bus_write(12'h3FC, 8'hA5);
    pins_now("R4 after output", 8'hFF, 8'hA5);
    bus_read(12'h3FC, 8'hA5, "R6 all outputs");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule